// File: doc/BRIEF.md
# Address-Matching Handshake Slave Interface

This block is the clocked slave end of a parallel bus made of a 16-bit address, a 32-bit data path and a two-wire ready/ack handshake. A local agent hands it one request at a time: a bus address, a word count and a direction. It then waits for the master to present that address with ready high. For each matching transfer it either puts the next word of a local buffer on the data bus or stores the bus data into that buffer. After that it completes the ready/ack handshake.

A buffer pointer starts at zero and moves up by one per word. A down-counter tracks the words left. When the counter runs out, the block drops back to idle and raises a done pulse for one cycle. Two wait timers, set by parameters, stretch the gap before ack rises and the gap before ack falls. This lets the protocol's timing windows be met at a given clock period. With the default values and a 5 ns clock, the gap from the address match to ack rising is 15 ns and the gap from ready falling to ack falling is 10 ns.

Top module: `hs_slave_if`

## Requirements
- R1: After reset, bus_ack_o, bus_data_oe_o, done_o, busy_o and buf_we_o are all 0.
- R2: While a request is pending, the block takes no step unless a rising edge samples bus_ready_i = 1 and bus_addr_i equal to the requested address. With a wrong address, or with ready low, ack, output enable and buffer write all stay 0.
- R3: For a send request (req_dir_i = 0), word n of the request (counting from 0) is read from buffer location n (buf_addr_o = n) and presented on bus_data_o. The pointer restarts at 0 for every new request.
- R4: For a receive request (req_dir_i = 1), bus_data_i is written to buffer location n with a single-cycle buf_we_o for word n. bus_data_oe_o stays 0 for the whole request.
- R5: bus_ack_o rises on the (PRE_WAIT+2)-th rising edge after the edge that sampled the address match.
- R6: bus_ack_o stays high until an edge samples bus_ready_i = 0. It then falls on the (POST_WAIT+1)-th rising edge after that edge.
- R7: In a send request, bus_data_oe_o goes high one edge after the match edge and goes low on the same edge where ack falls. It is 0 at all other times.
- R8: After the last word, done_o pulses high for exactly one cycle, on the edge where ack falls, and busy_o returns to 0. After any earlier word the block waits for the next match.
- R9: A request with a count of 0 produces a done_o pulse on the next edge with no bus activity, and busy_o stays 0.
- R10: req_valid_i is ignored while busy_o = 1. The transfer in progress is not disturbed and no new request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start pulse for a request; taken only while idle |
| req_dir_i | input | 1 | 0 = send buffer words to the bus, 1 = receive bus words into the buffer |
| req_addr_i | input | ADDR_W | Bus address the request answers to |
| req_count_i | input | CNT_W | Number of words in the request |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse when a request completes |
| buf_addr_o | output | BUF_AW | Local buffer word index (the pointer) |
| buf_rdata_i | input | DATA_W | Buffer read data at buf_addr_o (combinational read) |
| buf_we_o | output | 1 | Buffer write strobe, receive direction |
| buf_wdata_o | output | DATA_W | Buffer write data |
| bus_addr_i | input | ADDR_W | Bus address from the master |
| bus_data_i | input | DATA_W | Bus data from the master |
| bus_ready_i | input | 1 | Master ready strobe |
| bus_data_o | output | DATA_W | Data driven toward the bus |
| bus_data_oe_o | output | 1 | Output enable for bus_data_o |
| bus_ack_o | output | 1 | Slave acknowledge |

## Verification
The main function is tried with the following patterns:
- A three-word send. This shows that the pointer steps through distinct buffer words.
- A four-word receive with distinct bus words. Each word must land at its own index, and the output enable must never rise.
- A second send. This shows that the pointer restarts at zero.

Some stimulus sets ready high with a wrong address, and some sets the right address with ready low. This separates the address comparison from the ready sampling. A zero-count request and a start pulse injected mid-transfer check the two ways a request can be refused or finished early. Each word's ack rise and fall are timed in cycles, which separates the two wait timers from each other.

// File: rtl/hs_slave_pkg.sv
package hs_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MATCH, ST_DATA, ST_PRE, ST_ACK, ST_LOW, ST_POST, ST_REL
  } hs_state_e;

  typedef enum logic {
    DIR_SEND = 1'b0,
    DIR_RECV = 1'b1
  } hs_dir_e;
endpackage

// File: rtl/hs_addr_match.sv
module hs_addr_match #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_ready_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] own_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     own_addr_q <= '0;
    else if (load_i) own_addr_q <= req_addr_i;
  end

  assign hit_o = bus_ready_i && (bus_addr_i == own_addr_q);
endmodule

// File: rtl/hs_word_track.sv
module hs_word_track #(
  parameter int CNT_W = 8,
  parameter int PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             adv_ptr_i,
  input  logic             dec_cnt_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      ptr_q  <= '0;
      left_q <= count_i;
    end else begin
      if (adv_ptr_i) ptr_q <= ptr_q + 1'b1;
      if (dec_cnt_i && left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign ptr_o   = ptr_q;
  assign empty_o = (left_q == '0);
endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer #(
  parameter int LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] RELOAD = (LEN > 0) ? CW'(LEN - 1) : '0;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/hs_slave_if.sv
module hs_slave_if
  import hs_slave_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int BUF_AW    = 6,
  parameter int PRE_WAIT  = 1,
  parameter int POST_WAIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_dir_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic              buf_we_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_ready_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  output logic              bus_ack_o
);
  hs_state_e         st_q, st_d;
  hs_dir_e           dir_q;
  logic              ack_q, oe_q, done_q;
  logic [DATA_W-1:0] data_q;
  logic              hit, empty, pre_exp, post_exp;
  logic              accept;

  assign accept = (st_q == ST_IDLE) && req_valid_i;

  hs_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .clk_i, .rst_ni,
    .load_i     (accept),
    .req_addr_i (req_addr_i),
    .bus_addr_i (bus_addr_i),
    .bus_ready_i(bus_ready_i),
    .hit_o      (hit)
  );

  hs_word_track #(.CNT_W(CNT_W), .PTR_W(BUF_AW)) u_track (
    .clk_i, .rst_ni,
    .load_i   (accept),
    .count_i  (req_count_i),
    .adv_ptr_i(st_q == ST_DATA),
    .dec_cnt_i(st_q == ST_ACK),
    .ptr_o    (buf_addr_o),
    .empty_o  (empty)
  );

  hs_wait_timer #(.LEN(PRE_WAIT)) u_pre (
    .clk_i, .rst_ni,
    .load_i   (st_q == ST_DATA),
    .run_i    (st_q == ST_PRE),
    .expired_o(pre_exp)
  );

  hs_wait_timer #(.LEN(POST_WAIT)) u_post (
    .clk_i, .rst_ni,
    .load_i   (st_q == ST_LOW),
    .run_i    (st_q == ST_POST),
    .expired_o(post_exp)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i && req_count_i != '0) st_d = ST_MATCH;
      ST_MATCH: if (hit) st_d = ST_DATA;
      ST_DATA:  st_d = (PRE_WAIT == 0) ? ST_ACK : ST_PRE;
      ST_PRE:   if (pre_exp) st_d = ST_ACK;
      ST_ACK:   st_d = ST_LOW;
      ST_LOW:   if (!bus_ready_i) st_d = (POST_WAIT == 0) ? ST_REL : ST_POST;
      ST_POST:  if (post_exp) st_d = ST_REL;
      ST_REL:   st_d = empty ? ST_IDLE : ST_MATCH;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dir_q  <= DIR_SEND;
      ack_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= (accept && req_count_i == '0) || (st_q == ST_REL && empty);
      if (accept) dir_q <= hs_dir_e'(req_dir_i);
      if (st_q == ST_DATA && dir_q == DIR_SEND) begin
        data_q <= buf_rdata_i;
        oe_q   <= 1'b1;
      end
      if (st_q == ST_ACK) ack_q <= 1'b1;
      if (st_q == ST_REL) begin
        ack_q <= 1'b0;
        oe_q  <= 1'b0;
      end
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign buf_we_o      = (st_q == ST_DATA) && (dir_q == DIR_RECV);
  assign buf_wdata_o   = bus_data_i;
  assign bus_data_o    = data_q;
  assign bus_data_oe_o = oe_q;
  assign bus_ack_o     = ack_q;
endmodule

// File: rtl/hs_slave_if_chk.sv
module hs_slave_if_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              buf_we_o,
  input logic              bus_ready_i,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_data_oe_o,
  input logic              bus_ack_o
);
  // R1 / R8: idle means the bus is released
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_ack_o && !bus_data_oe_o && !buf_we_o));

  // R2: driving starts only after ready was sampled high
  p_oe_after_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_data_oe_o) |-> $past(bus_ready_i));

  // R3: driven word holds while acknowledged
  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_o && bus_data_oe_o) |-> $stable(bus_data_o));

  // R4: capture and drive never overlap
  p_we_no_oe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> !bus_data_oe_o);

  // R6: ack drops only after ready was low
  p_ack_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ack_o) |-> !$past(bus_ready_i));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5: ack rises only within a request
  p_ack_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_ack_o) |-> busy_o);
endmodule

bind hs_slave_if hs_slave_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .buf_we_o     (buf_we_o),
  .bus_ready_i  (bus_ready_i),
  .bus_data_o   (bus_data_o),
  .bus_data_oe_o(bus_data_oe_o),
  .bus_ack_o    (bus_ack_o)
);

// File: tb/sim_hs_slave_if.sv
`timescale 1ns/1ps
module sim_hs_slave_if;
  localparam int AW = 16, DW = 32, CW = 8, BAW = 6, PRE = 1, POST = 1;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 0, req_dir = 0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic          busy, done, buf_we;
  logic [BAW-1:0] buf_addr;
  logic [DW-1:0] buf_rdata, buf_wdata;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data_i = '0, bus_data_o;
  logic          bus_ready = 0, bus_oe, bus_ack;

  logic [DW-1:0] mem_tx [64];
  logic [DW-1:0] mem_rx [64];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  hs_slave_if #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .BUF_AW(BAW),
                .PRE_WAIT(PRE), .POST_WAIT(POST)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_dir_i(req_dir), .req_addr_i(req_addr),
    .req_count_i(req_count), .busy_o(busy), .done_o(done),
    .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata), .buf_we_o(buf_we),
    .buf_wdata_o(buf_wdata), .bus_addr_i(bus_addr), .bus_data_i(bus_data_i),
    .bus_ready_i(bus_ready), .bus_data_o(bus_data_o),
    .bus_data_oe_o(bus_oe), .bus_ack_o(bus_ack)
  );

  assign buf_rdata = mem_tx[buf_addr];
  always @(posedge clk) if (buf_we) mem_rx[buf_addr] <= buf_wdata;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic start(input logic [AW-1:0] a, input int cnt, input bit dir);
    req_addr = a; req_count = CW'(cnt); req_dir = dir; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  // One bus word as master; expected timing from R5/R6/R7/R8
  task automatic word(input logic [AW-1:0] a, input logic [DW-1:0] drv,
                      input bit send, input bit last, input logic [DW-1:0] exp_w,
                      input bit inject);
    int n;
    bus_addr = a; bus_data_i = drv; bus_ready = 1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!bus_ack) begin
        chk(bus_oe == (send && n >= 2), "R7", bus_oe, send && n >= 2);
        chk(done == 0, "R8", done, 0);
      end
      if (inject && n == 1) begin
        req_addr = 16'h9999; req_count = 5; req_dir = 1; req_valid = 1;
      end else req_valid = 0;
    end while (!bus_ack && n < 20);
    chk(n == PRE + 3, "R5", n, PRE + 3);
    if (send) chk(bus_data_o == exp_w, "R3", bus_data_o, exp_w);
    chk(bus_oe == send, "R7", bus_oe, send);
    bus_ready = 0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (bus_ack) chk(bus_oe == send, "R7", bus_oe, send);
    end while (bus_ack && n < 20);
    chk(n == POST + 2, "R6", n, POST + 2);
    chk(bus_oe == 0, "R7", bus_oe, 0);
    chk(done == last, "R8", done, last);
    if (last) begin
      chk(busy == 0, "R8", busy, 0);
      @(negedge clk);
      chk(done == 0, "R8", done, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_tx[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
      mem_rx[i] = '0;
    end
    #1;
    chk(!bus_ack && !bus_oe && !done && !busy && !buf_we, "R1",
        {bus_ack, bus_oe, done, busy, buf_we}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_ack && !bus_oe && !done && !busy, "R1", {bus_ack, bus_oe, done, busy}, 0);

    // send three words at address 0x1234
    start(16'h1234, 3, 0);
    chk(busy == 1, "R8", busy, 1);
    bus_addr = 16'h1235; bus_ready = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!bus_ack && !bus_oe && !buf_we, "R2", {bus_ack, bus_oe, buf_we}, 0);
    end
    bus_addr = 16'h1234; bus_ready = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!bus_ack && !bus_oe, "R2", {bus_ack, bus_oe}, 0);
    end
    for (int i = 0; i < 3; i++) word(16'h1234, '0, 1, i == 2, mem_tx[i], 0);

    // receive four words at 0x00F0
    start(16'h00F0, 4, 1);
    for (int i = 0; i < 4; i++) word(16'h00F0, 32'hC0DE_0000 + 32'(i) * 32'h11, 0, i == 3, '0, 0);
    for (int i = 0; i < 4; i++)
      chk(mem_rx[i] == 32'hC0DE_0000 + 32'(i) * 32'h11, "R4", mem_rx[i],
          32'hC0DE_0000 + 32'(i) * 32'h11);
    chk(mem_rx[4] == 0, "R4", mem_rx[4], 0);

    // zero-count request
    start(16'h0777, 0, 0);
    chk(done == 1 && busy == 0, "R9", {done, busy}, 2'b10);
    @(negedge clk);
    chk(done == 0 && !bus_ack && !bus_oe, "R9", {done, bus_ack, bus_oe}, 0);

    // second send restarts pointer; start pulse injected mid-transfer
    start(16'hBEEF, 2, 0);
    word(16'hBEEF, '0, 1, 0, mem_tx[0], 1);
    word(16'hBEEF, '0, 1, 1, mem_tx[1], 0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && !bus_ack, "R10", {busy, bus_ack}, 0);
    bus_addr = 16'h9999; bus_ready = 1;
    repeat (6) @(negedge clk);
    chk(!bus_ack && !buf_we && busy == 0, "R10", {bus_ack, buf_we, busy}, 0);
    bus_ready = 0;
    @(negedge clk);
    finish_run();
  end
endmodule